// File: doc/BRIEF.md
# Dual-Port GPIO Block with Flash Strobe and Sensor Clock Decoding

This block is a register-mapped general-purpose I/O unit with two ports, A and D. Each port has three registers: an output value, an input view and an output-enable mask. They are reached over a simple 32-bit register bus that takes only full-word accesses. The window is 0x5C bytes, which is 23 words. Every word in the window that is not an input view is plain read/write storage.

Some output bits also act as control lines. Three bits of the port A output value drive the latch and select strobes of an external NAND flash. On port D, a write that flips the clock bit produces a one-cycle clock-event pulse, together with the new clock level and a serial data bit, for a bit-banged temperature sensor. A read of an input view returns what the port drives: its output value masked by its enable. One external status pin is ORed in at a fixed bit: the flash ready line on port A and the sensor serial output on port D.

The bus is a single-cycle request. `bus_req` with `bus_we` high writes at the next clock edge. `bus_req` with `bus_we` low returns `bus_rdata` combinationally in the same cycle. The byte address is the word index shifted left by two.

Top module: `gpio_dual_port`

## Requirements
- R1: After reset every stored register, every strobe, the sensor clock level, the sensor data bit and the event pulse are zero.
- R2: A full-word write to word index i (byte address i*4, i below 23), other than the two input views, stores the value. A later read of that index returns it. Port A output sits at index 0x00, port A enable at 0x02, port D output at 0x10 and port D enable at 0x12.
- R3: A read of index 0x01 returns (port A output AND port A enable) OR (flash ready input << 7).
- R4: A read of index 0x11 returns (port D output AND port D enable) OR (sensor serial input << 4).
- R5: From the cycle after a write to index 0x00, the address-latch strobe equals bit 6 of the written value. The command-latch strobe equals bit 5 and the flash select equals bit 4. The strobes change only on such a write.
- R6: A write to index 0x10 whose bit 1 differs from the stored bit 1 raises the sensor event pulse for exactly the next cycle. In that cycle the sensor clock level equals the new bit 1 and the sensor data bit equals the written bit 4.
- R7: A write to index 0x10 whose bit 1 equals the stored bit 1 raises no event pulse and leaves the sensor data bit unchanged, although the register itself updates.
- R8: An access whose byte enables are not all ones, whose byte address is 0x5C or above, or whose low two address bits are not zero, changes nothing on write and reads as zero.
- R9: A write to an input-view index (0x01 or 0x11) does not change what that index reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | DW/8 | Byte enables, all ones required |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, same cycle, zero when no legal read |
| flash_ready | input | 1 | Flash ready status pin |
| sensor_sdo | input | 1 | Serial data from sensor |
| port_a_dout | output | DW | Port A output value |
| port_a_oe | output | DW | Port A output enable |
| port_d_dout | output | DW | Port D output value |
| port_d_oe | output | DW | Port D output enable |
| flash_ale | output | 1 | Flash address-latch strobe |
| flash_cle | output | 1 | Flash command-latch strobe |
| flash_ce | output | 1 | Flash select |
| sensor_evt | output | 1 | One-cycle sensor clock event |
| sensor_clk | output | 1 | Current sensor clock level |
| sensor_dat | output | 1 | Data bit captured with the last event |

## Verification
The assertions run on every cycle. They check that the flash strobes hold unless port A's output word is written, and that an event pulse coincides exactly with a change of the stored clock bit. They also check that the sensor data bit moves only with an event, and that a read with partial byte enables returns zero. Other properties depend on what was written before, so only the bench's scenarios can show them. These are the read-back of stored words across the whole window, the masked merge of the status pins, the rejection of illegal writes, and the exact data bit carried by each clock event.

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
  parameter int ADDR_W    = 8,
  parameter int DW        = 32,
  parameter int WIN_BYTES = 92,
  parameter int IDX_A_OUT = 'h00,
  parameter int IDX_A_IN  = 'h01,
  parameter int IDX_A_OE  = 'h02,
  parameter int IDX_D_OUT = 'h10,
  parameter int IDX_D_IN  = 'h11,
  parameter int IDX_D_OE  = 'h12,
  parameter int RDY_BIT   = 7,
  parameter int SDO_BIT   = 4,
  parameter int ALE_BIT   = 6,
  parameter int CLE_BIT   = 5,
  parameter int CE_BIT    = 4,
  parameter int SCK_BIT   = 1,
  parameter int SDA_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW/8-1:0]   bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              flash_ready,
  input  logic              sensor_sdo,
  output logic [DW-1:0]     port_a_dout,
  output logic [DW-1:0]     port_a_oe,
  output logic [DW-1:0]     port_d_dout,
  output logic [DW-1:0]     port_d_oe,
  output logic              flash_ale,
  output logic              flash_cle,
  output logic              flash_ce,
  output logic              sensor_evt,
  output logic              sensor_clk,
  output logic              sensor_dat
);
  localparam int IW    = ADDR_W - 2;
  localparam int NWORD = WIN_BYTES / 4;
  localparam logic [IW-1:0] NW_L  = IW'(NWORD);
  localparam logic [IW-1:0] AOUT  = IW'(IDX_A_OUT);
  localparam logic [IW-1:0] AIN   = IW'(IDX_A_IN);
  localparam logic [IW-1:0] AOE   = IW'(IDX_A_OE);
  localparam logic [IW-1:0] DOUT  = IW'(IDX_D_OUT);
  localparam logic [IW-1:0] DIN   = IW'(IDX_D_IN);
  localparam logic [IW-1:0] DOE   = IW'(IDX_D_OE);

  logic [DW-1:0] regs [NWORD];
  logic [2:0]    strobes;

  wire [IW-1:0] widx   = bus_addr[ADDR_W-1:2];
  wire          legal  = bus_req && (bus_be == '1) && (bus_addr[1:0] == 2'b00) && (widx < NW_L);
  wire          wr_ok  = legal && bus_we;
  wire          rd_ok  = legal && !bus_we;
  wire          wr_a   = wr_ok && (widx == AOUT);
  wire          wr_d   = wr_ok && (widx == DOUT);
  wire          toggle = wr_d && (bus_wdata[SCK_BIT] != regs[IDX_D_OUT][SCK_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) regs[i] <= '0;
    end else if (wr_ok && widx != AIN && widx != DIN) begin
      for (int i = 0; i < NWORD; i++)
        if (widx == IW'(i)) regs[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobes    <= '0;
      sensor_evt <= 1'b0;
      sensor_dat <= 1'b0;
    end else begin
      if (wr_a) strobes <= {bus_wdata[ALE_BIT], bus_wdata[CLE_BIT], bus_wdata[CE_BIT]};
      sensor_evt <= toggle;
      if (toggle) sensor_dat <= bus_wdata[SDA_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      if (widx == AIN)
        bus_rdata = (regs[IDX_A_OUT] & regs[IDX_A_OE]) | (DW'(flash_ready) << RDY_BIT);
      else if (widx == DIN)
        bus_rdata = (regs[IDX_D_OUT] & regs[IDX_D_OE]) | (DW'(sensor_sdo) << SDO_BIT);
      else
        for (int i = 0; i < NWORD; i++)
          if (widx == IW'(i)) bus_rdata = regs[i];
    end
  end

  assign port_a_dout = regs[IDX_A_OUT];
  assign port_a_oe   = regs[IDX_A_OE];
  assign port_d_dout = regs[IDX_D_OUT];
  assign port_d_oe   = regs[IDX_D_OE];
  assign flash_ale   = strobes[2];
  assign flash_cle   = strobes[1];
  assign flash_ce    = strobes[0];
  assign sensor_clk  = regs[IDX_D_OUT][SCK_BIT];

  a_r5_strobes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_a |=> $stable({flash_ale, flash_cle, flash_ce}));

  a_r6_evt_on_clk_change: assert property (@(posedge clk) disable iff (!rst_n)
    sensor_evt |-> (sensor_clk != $past(sensor_clk)));

  a_r7_no_evt_when_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sensor_clk == $past(sensor_clk)) |-> !sensor_evt);

  a_r6_dat_moves_with_evt: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sensor_dat) |-> sensor_evt);

  a_r8_partial_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_be != '1) |-> (bus_rdata == '0));

  a_r2_oe_regs_not_views: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && (widx == AOE || widx == DOE)) |=> ($stable(port_a_dout) && $stable(port_d_dout)));
endmodule

// File: tb/gpio_dual_port_test.sv
module gpio_dual_port_test;
  logic        clk = 0, rst_n = 0;
  logic        bus_req = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        flash_ready = 0, sensor_sdo = 0;
  logic [31:0] port_a_dout, port_a_oe, port_d_dout, port_d_oe;
  logic        flash_ale, flash_cle, flash_ce, sensor_evt, sensor_clk, sensor_dat;

  int vectors = 0, miscompares = 0;
  logic [31:0] mdl [23];
  logic        exp_dat;

  gpio_dual_port uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] r);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_be = be;
    #1 r = bus_rdata;
    bus_req = 0;
  endtask

  function automatic logic [31:0] view_a();
    return (mdl[0] & mdl[2]) | (32'(flash_ready) << 7);
  endfunction
  function automatic logic [31:0] view_d();
    return (mdl[16] & mdl[18]) | (32'(sensor_sdo) << 4);
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] r;
    for (int i = 0; i < 23; i++) begin
      rd(8'(i * 4), 4'hF, r);
      if (i == 1) chk(r, view_a(), tag);
      else if (i == 17) chk(r, view_d(), tag);
      else chk(r, mdl[i], tag);
    end
  endtask

  initial begin
    #800000;
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] v, prev;
    for (int i = 0; i < 23; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk({29'd0, flash_ale, flash_cle, flash_ce}, 32'd0, "R1 strobes");
    chk({29'd0, sensor_evt, sensor_clk, sensor_dat}, 32'd0, "R1 sensor");
    chk(port_a_dout | port_a_oe | port_d_dout | port_d_oe, 32'd0, "R1 ports");
    check_all("R1 registers");

    // R2 fill whole window
    for (int i = 0; i < 23; i++) begin
      v = 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0111);
      if (i != 1 && i != 17) begin
        wr(8'(i * 4), v, 4'hF);
        mdl[i] = v;
      end
    end
    check_all("R2 readback");
    chk(port_a_oe, mdl[2], "R2 port_a_oe pin");
    chk(port_d_oe, mdl[18], "R2 port_d_oe pin");

    // R3 / R4 merged views, sweep patterns and both pin levels
    for (int p = 0; p < 6; p++) begin
      v = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF : 32'h0F0F_00F0 ^ (32'(p) * 32'h1357_9BDF);
      wr(8'h00, ~v ^ 32'h0000_0080, 4'hF); mdl[0]  = ~v ^ 32'h0000_0080;
      wr(8'h08, v, 4'hF);                  mdl[2]  = v;
      wr(8'h40, v ^ 32'h0000_0010, 4'hF);  mdl[16] = v ^ 32'h0000_0010;
      wr(8'h48, ~v, 4'hF);                 mdl[18] = ~v;
      for (int s = 0; s < 4; s++) begin
        flash_ready = s[0]; sensor_sdo = s[1];
        rd(8'h04, 4'hF, r); chk(r, view_a(), "R3 port A view");
        rd(8'h44, 4'hF, r); chk(r, view_d(), "R4 port D view");
      end
    end
    flash_ready = 0; sensor_sdo = 0;

    // R5 strobe decoding, all eight combinations
    for (int k = 0; k < 8; k++) begin
      v = (32'(k) << 4) | 32'h0000_0F0F;
      wr(8'h00, v, 4'hF); mdl[0] = v;
      chk({29'd0, flash_ale, flash_cle, flash_ce}, 32'(k), "R5 strobes");
      chk(port_a_dout, v, "R5 port_a_dout");
    end

    // R6 / R7 sensor clock events
    wr(8'h40, 32'h0, 4'hF); mdl[16] = 0;
    @(negedge clk); #1;
    prev = 0; exp_dat = sensor_dat;
    for (int k = 0; k < 32; k++) begin
      v = (32'((k >> 1) & 1) << 1) | (32'(k & 1) << 4) | (32'(k) << 8);
      wr(8'h40, v, 4'hF); mdl[16] = v;
      if (v[1] != prev[1]) begin
        exp_dat = v[4];
        chk({31'd0, sensor_evt}, 1, "R6 event pulse");
      end else begin
        chk({31'd0, sensor_evt}, 0, "R7 no event");
      end
      chk({31'd0, sensor_clk}, {31'd0, v[1]}, "R6 clock level");
      chk({31'd0, sensor_dat}, {31'd0, exp_dat}, "R6 R7 data bit");
      @(negedge clk); #1;
      chk({31'd0, sensor_evt}, 0, "R6 single cycle");
      prev = v;
    end
    rd(8'h40, 4'hF, r); chk(r, mdl[16], "R7 register updated");

    // R8 partial byte enables
    for (int b = 0; b < 15; b++) begin
      wr(8'h00, 32'hFFFF_FFFF, 4'(b));
      chk({29'd0, flash_ale, flash_cle, flash_ce}, 32'(mdl[0][6:4]), "R8 strobes held");
      rd(8'h00, 4'(b), r); chk(r, 0, "R8 partial read zero");
      rd(8'h00, 4'hF, r);  chk(r, mdl[0], "R8 partial write ignored");
    end
    // R8 outside window and misaligned
    for (int a = 'h5C; a < 256; a += 4) begin
      wr(8'(a), 32'hDEAD_BEEF, 4'hF);
      rd(8'(a), 4'hF, r); chk(r, 0, "R8 out-of-window read");
    end
    for (int a = 1; a < 4; a++) begin
      wr(8'(a), 32'h0000_0070, 4'hF);
      rd(8'(a), 4'hF, r); chk(r, 0, "R8 misaligned read");
    end
    check_all("R8 window untouched");

    // R9 writes to input views
    wr(8'h04, 32'hFFFF_FFFF, 4'hF);
    wr(8'h44, 32'hFFFF_FFFF, 4'hF);
    flash_ready = 1; sensor_sdo = 1;
    rd(8'h04, 4'hF, r); chk(r, view_a(), "R9 port A view unchanged");
    rd(8'h44, 4'hF, r); chk(r, view_d(), "R9 port D view unchanged");
    check_all("R9 window");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule